// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the status-register front end of a serial NOR flash. It sits behind an SPI target port working in mode 0, with bytes sent most significant bit first. It decodes four opcodes: set write-enable, clear write-enable, read status and write status. It holds a write-enable latch, a status-write lock bit and a quad-enable bit. A write-status command is accepted only when the write-enable latch is set and the device is not in hardware-protected mode. Hardware-protected mode is the case where the active-low protect input is low while the lock bit is set.

All SPI inputs and the protect input are sampled with the system clock through two-flop synchronisers. Edges of the SPI clock and chip select are detected in the system clock domain, so the system clock must run well above the SPI clock. State changes take effect when chip select rises. The protection decision is taken once per frame, when the opcode byte completes. Parameters select between a one-byte and a two-byte status write, and decide whether quad-enable is visible in the status byte.

Top module: `spi_sr_guard`

## Requirements
- R1: Opcode 0x06, sent as a complete byte, sets the write-enable latch when chip select rises. The latch is read back as status bit 1.
- R2: Opcode 0x04 clears the write-enable latch when chip select rises.
- R3: Opcode 0x05 returns the status byte, starting with the byte that follows the opcode. The byte is laid out as: bit 7 lock bit, bit 6 quad-enable (zero when QE_IN_STATUS=0), bit 1 write-enable latch, all other bits zero.
- R4: A status read repeats the current status byte for as long as chip select stays low.
- R5: Opcode 0x01 sent while the write-enable latch is clear is ignored: no status field changes.
- R6: Opcode 0x01 is refused when the synchronised protect input is low and the lock bit is set. The refused frame changes nothing, and the write-enable latch stays set. Every other combination of protect level and lock bit permits the write. The protect level is judged when the opcode byte completes.
- R7: A write-status frame that completes loads the lock bit from bit 7 of the first data byte and clears the write-enable latch.
- R8: With TWO_BYTE=1, a write-status frame needs two data bytes, and quad-enable is loaded from bit 1 of the second data byte. With TWO_BYTE=0, one data byte completes the write and quad-enable stays 0.
- R9: A write-status frame whose chip select rises before all the required data bytes have arrived changes no status field.
- R10: After reset, the lock bit, quad-enable and write-enable latch are all 0, and the protect input is taken as high.
- R11: An opcode outside the four decoded values changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Active-low chip select |
| spiClk | input | 1 | SPI serial clock, mode 0 |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host |
| protectN | input | 1 | Active-low write-protect input |

## Verification
Two things can meet within a single write-status frame: the protect input changing, and the protection decision being applied to the frame. The bench provokes this by dropping protectN while the payload of an already accepted write is still arriving. It expects the write to complete, because the decision was fixed when the opcode byte ended. The bench also toggles the protect input between random frames, so that every pairing of pin level, lock bit and write-enable state reaches the write-status decoder. After each frame, a bench model predicts the status byte that a following read must return.

// File: rtl/spi_sr_guard_pkg.sv
package spi_sr_guard_pkg;

  localparam logic [7:0] OpSetWel   = 8'h06;
  localparam logic [7:0] OpClrWel   = 8'h04;
  localparam logic [7:0] OpRdStatus = 8'h05;
  localparam logic [7:0] OpWrStatus = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_WDATA,
    ST_READ,
    ST_DRAIN
  } frameState_t;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_SET,
    PEND_CLR
  } pendOp_t;

  typedef struct packed {
    logic shiftIn;
    logic storeByte0;
    logic storeByte1;
    logic setWel;
    logic clrWel;
    logic commit;
    logic txLoad;
    logic txShift;
    logic txClear;
  } strobes_t;

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RESET_VAL;
        else       stageQ[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= RESET_VAL;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
  import spi_sr_guard_pkg::*;
#(
  parameter bit TWO_BYTE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csSync,
  input  logic       sclkSync,
  input  logic       protectSync,
  input  logic [7:0] rxNext,
  input  logic       welQ,
  input  logic       srwdQ,
  output strobes_t   st
);

  localparam logic [1:0] NeedBytes = TWO_BYTE ? 2'd2 : 2'd1;

  frameState_t state;
  pendOp_t     pend;
  logic        csDly, sclkDly;
  logic [2:0]  bitCnt;
  logic [1:0]  byteCnt;

  logic csRise, csFall, sclkRise, sclkFall, byteDone, writeOk, inWrite;

  assign csRise   = !csDly && csSync;
  assign csFall   = csDly && !csSync;
  assign sclkRise = !sclkDly && sclkSync && !csSync;
  assign sclkFall = sclkDly && !sclkSync && !csSync;
  assign byteDone = sclkRise && (bitCnt == 3'd7) && (state != ST_IDLE);
  assign writeOk  = welQ && !(!protectSync && srwdQ);
  assign inWrite  = (state == ST_WDATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csDly   <= 1'b1;
      sclkDly <= 1'b0;
    end else begin
      csDly   <= csSync;
      sclkDly <= sclkSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pend    <= PEND_NONE;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (csRise) begin
      state   <= ST_IDLE;
      pend    <= PEND_NONE;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (csFall) begin
      state   <= ST_OPCODE;
      pend    <= PEND_NONE;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (sclkRise && state != ST_IDLE) begin
      bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        unique case (state)
          ST_OPCODE: begin
            unique case (rxNext)
              OpSetWel:   begin pend <= PEND_SET; state <= ST_DRAIN; end
              OpClrWel:   begin pend <= PEND_CLR; state <= ST_DRAIN; end
              OpRdStatus: state <= ST_READ;
              OpWrStatus: state <= writeOk ? ST_WDATA : ST_DRAIN;
              default:    state <= ST_DRAIN;
            endcase
          end
          ST_WDATA: if (byteCnt != 2'd2) byteCnt <= byteCnt + 2'd1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    st            = '0;
    st.shiftIn    = sclkRise && (state != ST_IDLE);
    st.storeByte0 = byteDone && inWrite && (byteCnt == 2'd0);
    st.storeByte1 = byteDone && inWrite && (byteCnt == 2'd1);
    st.setWel     = csRise && (state == ST_DRAIN) && (pend == PEND_SET);
    st.clrWel     = csRise && (state == ST_DRAIN) && (pend == PEND_CLR);
    st.commit     = csRise && inWrite && (byteCnt >= NeedBytes);
    st.txLoad     = sclkFall && (state == ST_READ) && (bitCnt == 3'd0);
    st.txShift    = sclkFall && (state == ST_READ) && (bitCnt != 3'd0);
    st.txClear    = csRise || csFall;
  end

  AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inWrite) |-> $past(welQ)); // R5
  AST_WRITE_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inWrite) |-> $past(protectSync || !srwdQ)); // R6
  AST_SHORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && byteCnt < NeedBytes) |-> !st.commit); // R9

endmodule

// File: rtl/spi_sr_dp.sv
module spi_sr_dp
  import spi_sr_guard_pkg::*;
#(
  parameter bit TWO_BYTE = 1'b1,
  parameter bit QE_IN_STATUS = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mosiSync,
  input  strobes_t   st,
  output logic [7:0] rxNext,
  output logic       welQ,
  output logic       srwdQ,
  output logic       misoOut
);

  logic [6:0] rxShift;
  logic       srwdPend, qePend, qeQ;
  logic [7:0] txReg, statusByte;

  assign rxNext     = {rxShift, mosiSync};
  assign statusByte = {srwdQ, (QE_IN_STATUS ? qeQ : 1'b0), 4'b0000, welQ, 1'b0};
  assign misoOut    = txReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      srwdPend <= 1'b0;
      qePend   <= 1'b0;
    end else begin
      if (st.shiftIn)    rxShift  <= rxNext[6:0];
      if (st.storeByte0) srwdPend <= rxNext[7];
      if (st.storeByte1) qePend   <= rxNext[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      srwdQ <= 1'b0;
      qeQ   <= 1'b0;
    end else if (st.commit) begin
      welQ  <= 1'b0;
      srwdQ <= srwdPend;
      if (TWO_BYTE) qeQ <= qePend;
    end else if (st.setWel) begin
      welQ <= 1'b1;
    end else if (st.clrWel) begin
      welQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           txReg <= '0;
    else if (st.txClear) txReg <= '0;
    else if (st.txLoad)  txReg <= statusByte;
    else if (st.txShift) txReg <= {txReg[6:0], 1'b0};
  end

  AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.setWel, st.clrWel, st.commit})); // R7
  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> !welQ); // R7
  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    st.setWel |=> welQ); // R1
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(srwdQ)); // R9
  AST_QE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(qeQ)); // R8

endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard
  import spi_sr_guard_pkg::*;
#(
  parameter bit TWO_BYTE = 1'b1,
  parameter bit QE_IN_STATUS = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiCsN,
  input  logic spiClk,
  input  logic spiMosi,
  output logic spiMiso,
  input  logic protectN
);

  localparam int PinCount = 4;

  logic [PinCount-1:0] pinsSync;
  logic [7:0] rxNext;
  logic welQ, srwdQ;
  strobes_t st;

  spi_sr_sync #(
    .WIDTH(PinCount),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(4'b1001)
  ) sync_i (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({spiCsN, spiClk, spiMosi, protectN}),
    .syncOut(pinsSync)
  );

  spi_sr_ctrl #(.TWO_BYTE(TWO_BYTE)) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .csSync(pinsSync[3]),
    .sclkSync(pinsSync[2]),
    .protectSync(pinsSync[0]),
    .rxNext(rxNext),
    .welQ(welQ),
    .srwdQ(srwdQ),
    .st(st)
  );

  spi_sr_dp #(.TWO_BYTE(TWO_BYTE), .QE_IN_STATUS(QE_IN_STATUS)) dp_i (
    .clk(clk),
    .rstN(rstN),
    .mosiSync(pinsSync[1]),
    .st(st),
    .rxNext(rxNext),
    .welQ(welQ),
    .srwdQ(srwdQ),
    .misoOut(spiMiso)
  );

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinsSync[3]) |=> !spiMiso); // R3

endmodule

// File: tb/spi_sr_guard_tb.sv
module spi_sr_guard_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiClk = 1'b0, spiMosi = 1'b0, protectN = 1'b1;
  logic misoA, misoB;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] txBuf [4];
  logic [7:0] rxA [4];
  logic [7:0] rxB [4];
  int dropAt = -1;

  bit welA, srwdA, qeA, welB, srwdB;

  always #4 clk = ~clk;

  spi_sr_guard #(.TWO_BYTE(1'b1), .QE_IN_STATUS(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiClk(spiClk),
    .spiMosi(spiMosi), .spiMiso(misoA), .protectN(protectN));

  spi_sr_guard #(.TWO_BYTE(1'b0), .QE_IN_STATUS(1'b0)) dut_one_i (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiClk(spiClk),
    .spiMosi(spiMosi), .spiMiso(misoB), .protectN(protectN));

  function automatic logic [7:0] expStatus(bit w, bit s, bit q);
    return {s, q, 4'b0000, w, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int n);
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        if (dropAt == i && b == 7) protectN = 1'b0;
        spiMosi = txBuf[i][b];
        repeat (8) @(negedge clk);
        rxA[i][b] = misoA;
        rxB[i][b] = misoB;
        spiClk = 1'b1;
        repeat (8) @(negedge clk);
        spiClk = 1'b0;
      end
    end
    repeat (8) @(negedge clk);
    spiCsN = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  // Sends opcode plus nData data bytes and advances both reference models.
  task automatic frame(input logic [7:0] op, input logic [7:0] d0, input logic [7:0] d1, input int nData);
    bit pinAtDecode = protectN;
    txBuf[0] = op; txBuf[1] = d0; txBuf[2] = d1; txBuf[3] = 8'h00;
    xfer(1 + nData);
    if (op == 8'h06) begin welA = 1; welB = 1; end
    else if (op == 8'h04) begin welA = 0; welB = 0; end
    else if (op == 8'h01) begin
      if (welA && !(!pinAtDecode && srwdA) && nData >= 2) begin
        srwdA = d0[7]; qeA = d1[1]; welA = 0;
      end
      if (welB && !(!pinAtDecode && srwdB) && nData >= 1) begin
        srwdB = d0[7]; welB = 0;
      end
    end
  endtask

  task automatic checkStatus(input string tag, input int nRead);
    logic [7:0] ea, eb;
    txBuf[0] = 8'h05; txBuf[1] = 8'h00; txBuf[2] = 8'h00; txBuf[3] = 8'h00;
    xfer(1 + nRead);
    ea = expStatus(welA, srwdA, qeA);
    eb = expStatus(welB, srwdB, 1'b0);
    for (int k = 1; k <= nRead; k++) begin
      chk(rxA[k] === ea, {tag, " two-byte"}, rxA[k], ea);
      chk(rxB[k] === eb, {tag, " one-byte"}, rxB[k], eb);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed1234;
    void'($urandom(seed));
    welA = 0; srwdA = 0; qeA = 0; welB = 0; srwdB = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    checkStatus("R10 reset", 1);
    frame(8'h06, 8'h00, 8'h00, 0); checkStatus("R1 set wel", 1);
    frame(8'h04, 8'h00, 8'h00, 0); checkStatus("R2 clear wel", 1);
    frame(8'h01, 8'hFF, 8'hFF, 2); checkStatus("R5 write without wel", 1);
    frame(8'h06, 8'h00, 8'h00, 0);
    frame(8'h01, 8'h80, 8'h02, 2); checkStatus("R7 R8 commit", 1);
    protectN = 1'b0; repeat (8) @(negedge clk);
    frame(8'h06, 8'h00, 8'h00, 0);
    frame(8'h01, 8'h00, 8'h00, 2); checkStatus("R6 locked refusal", 1);
    protectN = 1'b1; repeat (8) @(negedge clk);
    frame(8'h01, 8'h00, 8'h00, 2); checkStatus("R6 pin high permits", 1);
    protectN = 1'b0; repeat (8) @(negedge clk);
    frame(8'h06, 8'h00, 8'h00, 0);
    frame(8'h01, 8'h80, 8'h00, 2); checkStatus("R6 lock clear permits", 1);
    protectN = 1'b1; repeat (8) @(negedge clk);
    frame(8'h06, 8'h00, 8'h00, 0);
    frame(8'h01, 8'h00, 8'h02, 1); checkStatus("R9 R8 short frame", 1);
    frame(8'h06, 8'h00, 8'h00, 0);
    frame(8'h9F, 8'h00, 8'h00, 1); checkStatus("R11 unknown opcode", 1);
    checkStatus("R4 repeated read", 3);
    frame(8'h06, 8'h00, 8'h00, 0);
    frame(8'h01, 8'h80, 8'h00, 2);
    frame(8'h06, 8'h00, 8'h00, 0);
    dropAt = 1;
    frame(8'h01, 8'h00, 8'h02, 2);
    dropAt = -1;
    checkStatus("R6 pin drop mid payload", 1);
    protectN = 1'b1; repeat (8) @(negedge clk);

    for (int it = 0; it < 100; it++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 5);
      int nd = $urandom_range(0, 2);
      logic [7:0] d0 = 8'($urandom);
      logic [7:0] d1 = 8'($urandom);
      op = (sel == 0) ? 8'h06 : (sel == 1) ? 8'h04 : (sel == 2) ? 8'h05 :
           (sel == 5) ? 8'hA5 : 8'h01;
      if ($urandom_range(0, 3) == 0) protectN = ~protectN;
      repeat (8) @(negedge clk);
      if ($urandom_range(0, 1) == 1) frame(8'h06, 8'h00, 8'h00, 0);
      frame(op, d0, d1, nd);
      checkStatus("R8 random frame", 1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule